// File: doc/BRIEF.md
# I2C Target Register Bridge

This block lets an external I2C controller read and write a 32-bit register space with 22-bit word addresses. It listens on oversampled SCL and SDA lines, answers to a device address set by static pins, and turns the bytes it receives into single-cycle requests on a simple internal register bus. A strap input picks 7-bit or 10-bit addressing. SDA is never driven high; the block only pulls it low through an output-enable.

A write carries three word-address bytes and then a four-byte data word. The controller may stop after the address bytes. Those bytes still load the address, and it is kept for later reads. A read is a header with the R/W bit set, followed by four data bytes. In 10-bit mode only the first header byte is sent for a read. The data returned is the word at the last loaded address.

Top module: `i2c_reg_bridge`

## Requirements
- R1: With `mode10_i` low, a first byte equal to {dev_id_i[6:0], R/W} is acknowledged by pulling SDA low during the ninth clock; dev_id_i[9:7] has no effect on matching.
- R2: With `mode10_i` high, a write header is the byte {5'b11110, dev_id_i[9:8], 0} followed by the byte dev_id_i[7:0], and both bytes are acknowledged.
- R3: A header byte that does not match is not acknowledged. SDA stays released for the rest of that transaction and no register strobe is raised.
- R4: After the header, three address bytes are received. The low six bits of the first byte are address bits [21:16], and its top two bits are ignored. Four data bytes follow, most significant first, and each byte is acknowledged. The fourth data byte gives exactly one `reg_we_o` pulse with that address and word.
- R5: A STOP, or a repeated START, that arrives before the fourth data byte has been acknowledged produces no write strobe.
- R6: Once the third address byte has been received, the address is held across STOP, through traffic addressed to other devices, and through a cancelled write. The next read uses it.
- R7: A read header ({dev_id_i[6:0],1} in 7-bit mode, or only {5'b11110, dev_id_i[9:8], 1} in 10-bit mode) is acknowledged and gives one `reg_re_o` pulse. The word on `reg_rdata_i` in that cycle is latched and returned as four bytes, most significant bit first.
- R8: When the controller NACKs a read byte, SDA is released and the block waits for the next START.
- R9: `sda_oe_o` changes only while the filtered SCL is low. `reg_we_o` and `reg_re_o` are each one cycle wide and are never high together.
- R10: A pulse on SCL one clock wide is rejected by the synchroniser and 3-sample majority filter, and does not disturb a transfer in progress.
- R11: During reset `sda_oe_o`, `reg_we_o` and `reg_re_o` are low, and `reg_addr_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, oversamples the I2C lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | Pull SDA low when high |
| mode10_i | input | 1 | Strap: 1 = 10-bit device address, 0 = 7-bit |
| dev_id_i | input | 10 | Static device address pins |
| reg_addr_o | output | 22 | Register word address (last loaded) |
| reg_wdata_o | output | 32 | Register write data |
| reg_we_o | output | 1 | Register write strobe, one cycle |
| reg_re_o | output | 1 | Register read strobe, one cycle |
| reg_rdata_i | input | 32 | Register read data, valid while `reg_re_o` is high |

## Verification
The bench builds the bridge with its defaults: a 22-bit address, a 32-bit data word, two synchroniser stages and a 3-sample filter window. With these values the address needs three bytes, and the two spare bits in the first byte can be set to non-zero patterns to show they are dropped. The four-byte word lets a transfer be cut off inside the last byte, and a read can be ended early after two bytes. The bit period is 32 clocks, so the filter delay of about five clocks lets the target's ACK and data edges settle well before the controller samples them. It also means a one-clock SCL spike gets only one of the three filter samples and is rejected.

// File: rtl/i2c_br_pkg.sv
package i2c_br_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV1,
    ST_DEV2,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } br_state_e;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int WIN         = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int HALF = WIN / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [WIN-1:0]         win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      win_q  <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      win_q  <= {win_q[WIN-2:0], sync_q[SYNC_STAGES-1]};
      line_o <= ($countones(win_q) > HALF);
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA moving while SCL stays high
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_br_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic              mode10_i,
  input  logic [9:0]        dev_id_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o
);
  localparam int NBYTES = DATA_W / 8;
  localparam int ABYTES = (ADDR_W + 7) / 8;
  localparam int MAXB   = (NBYTES > ABYTES) ? NBYTES : ABYTES;
  localparam int IDX_W  = $clog2(MAXB) + 1;
  localparam logic [IDX_W-1:0] LAST_A = IDX_W'(ABYTES - 1);
  localparam logic [IDX_W-1:0] LAST_D = IDX_W'(NBYTES - 1);

  br_state_e         state_q, nxt_q, nxt;
  logic [3:0]        bit_q;
  logic [7:0]        sh_q;
  logic              ack_q, mnack_q, hit, rd_req;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] astage_q;
  logic [DATA_W-1:0] wstage_q, rd_q;

  // decode of a completed byte in a receive state
  always_comb begin
    hit    = 1'b0;
    nxt    = ST_IDLE;
    rd_req = 1'b0;
    case (state_q)
      ST_DEV1: begin
        rd_req = sh_q[0];
        if (mode10_i) begin
          hit = (sh_q[7:3] == 5'b11110) && (sh_q[2:1] == dev_id_i[9:8]);
          nxt = sh_q[0] ? ST_RDATA : ST_DEV2;
        end else begin
          hit = (sh_q[7:1] == dev_id_i[6:0]);
          nxt = sh_q[0] ? ST_RDATA : ST_ADDR;
        end
      end
      ST_DEV2: begin
        hit = (sh_q == dev_id_i[7:0]);
        nxt = ST_ADDR;
      end
      ST_ADDR: begin
        hit = 1'b1;
        nxt = (idx_q == LAST_A) ? ST_WDATA : ST_ADDR;
      end
      ST_WDATA: begin
        hit = 1'b1;
        nxt = (idx_q == LAST_D) ? ST_IDLE : ST_WDATA;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      nxt_q       <= ST_IDLE;
      bit_q       <= '0;
      sh_q        <= '0;
      ack_q       <= 1'b0;
      mnack_q     <= 1'b0;
      idx_q       <= '0;
      astage_q    <= '0;
      wstage_q    <= '0;
      rd_q        <= '0;
      sda_oe_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      reg_we_o    <= 1'b0;
      reg_re_o    <= 1'b0;
    end else begin
      reg_we_o <= 1'b0;
      reg_re_o <= 1'b0;
      if (reg_re_o) rd_q <= reg_rdata_i;
      if (start_i) begin
        state_q  <= ST_DEV1;
        bit_q    <= '0;
        ack_q    <= 1'b0;
        idx_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        ack_q    <= 1'b0;
        sda_oe_o <= 1'b0;
      end else begin
        case (state_q)
          ST_DEV1, ST_DEV2, ST_ADDR, ST_WDATA: begin
            if (scl_rise_i && !ack_q) begin
              sh_q  <= {sh_q[6:0], sda_i};
              bit_q <= bit_q + 4'd1;
            end else if (scl_fall_i && !ack_q && bit_q == 4'd8) begin
              if (hit) begin
                ack_q    <= 1'b1;
                sda_oe_o <= 1'b1;
                nxt_q    <= nxt;
                case (state_q)
                  ST_DEV1: begin
                    idx_q    <= '0;
                    reg_re_o <= rd_req;
                  end
                  ST_ADDR: begin
                    astage_q <= {astage_q[ADDR_W-9:0], sh_q};
                    if (idx_q == LAST_A) begin
                      reg_addr_o <= {astage_q[ADDR_W-9:0], sh_q};
                      idx_q      <= '0;
                    end else begin
                      idx_q <= idx_q + 1'b1;
                    end
                  end
                  ST_WDATA: begin
                    wstage_q <= {wstage_q[DATA_W-9:0], sh_q};
                    idx_q    <= idx_q + 1'b1;
                    if (idx_q == LAST_D) begin
                      reg_wdata_o <= {wstage_q[DATA_W-9:0], sh_q};
                      reg_we_o    <= 1'b1;
                    end
                  end
                  default: ;
                endcase
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (scl_fall_i && ack_q) begin
              ack_q    <= 1'b0;
              bit_q    <= '0;
              state_q  <= nxt_q;
              sda_oe_o <= (nxt_q == ST_RDATA) ? ~rd_q[DATA_W-1] : 1'b0;
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              if (ack_q) mnack_q <= sda_i;
              else       bit_q   <= bit_q + 4'd1;
            end else if (scl_fall_i) begin
              if (ack_q) begin
                ack_q <= 1'b0;
                if (mnack_q || idx_q == LAST_D) begin
                  state_q  <= ST_IDLE;
                  sda_oe_o <= 1'b0;
                end else begin
                  idx_q    <= idx_q + 1'b1;
                  bit_q    <= '0;
                  sda_oe_o <= ~rd_q[DATA_W-1];
                end
              end else if (bit_q == 4'd8) begin
                rd_q     <= rd_q << 1;
                sda_oe_o <= 1'b0;
                ack_q    <= 1'b1;
              end else begin
                rd_q     <= rd_q << 1;
                sda_oe_o <= ~rd_q[DATA_W-2];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_bridge.sv
module i2c_reg_bridge #(
  parameter int ADDR_W      = 22,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_WIN    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              mode10_i,
  input  logic [9:0]        dev_id_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic [1:0] raw, filt;
  logic       scl_f, sda_f;
  logic       scl_rise, scl_fall, start, stop;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_glitch_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .WIN        (FILT_WIN)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw[g]),
      .line_o(filt[g])
    );
  end

  assign scl_f = filt[0];
  assign sda_f = filt[1];

  i2c_bus_events u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_f),
    .sda_i     (sda_f),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start),
    .stop_o    (stop)
  );

  i2c_target_fsm #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .sda_i      (sda_f),
    .mode10_i   (mode10_i),
    .dev_id_i   (dev_id_i),
    .reg_rdata_i(reg_rdata_i),
    .sda_oe_o   (sda_oe_o),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_we_o   (reg_we_o),
    .reg_re_o   (reg_re_o)
  );
endmodule

// File: rtl/i2c_reg_bridge_chk.sv
module i2c_reg_bridge_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_f,
  input logic sda_oe_o,
  input logic reg_we_o,
  input logic reg_re_o
);
  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));
  // R4
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  // R7
  re_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);
  // R9
  sda_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_f);
endmodule

bind i2c_reg_bridge i2c_reg_bridge_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scl_f   (scl_f),
  .sda_oe_o(sda_oe_o),
  .reg_we_o(reg_we_o),
  .reg_re_o(reg_re_o)
);

// File: tb/tb_i2c_reg_bridge.sv
`timescale 1ns/1ps
module tb_i2c_reg_bridge;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        scl_m = 1'b1, sda_m = 1'b1, glitch = 1'b0, glitch_en = 1'b0;
  logic        mode10 = 1'b0;
  logic [9:0]  dev_id = '0;
  logic        sda_oe, reg_we, reg_re;
  logic [21:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        scl_line, sda_line;

  assign scl_line = scl_m | glitch;
  assign sda_line = sda_m & ~sda_oe;

  function automatic logic [31:0] model(input logic [21:0] a);
    return {a, 10'h155} ^ 32'h5A3C_0F96;
  endfunction
  assign reg_rdata = model(reg_addr);

  i2c_reg_bridge dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .mode10_i(mode10), .dev_id_i(dev_id),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_we_o(reg_we),
    .reg_re_o(reg_re), .reg_rdata_i(reg_rdata)
  );

  int n_chk = 0, n_err = 0;
  int we_cnt = 0, re_cnt = 0, oe_cyc = 0, r9_viol = 0;
  logic [21:0] we_addr = '0, re_addr = '0;
  logic [31:0] we_data = '0;
  logic oe_prev = 1'b0;
  bit done = 0;

  // monitor, sampled 1 ns after the rising edge
  always @(posedge clk) begin
    #1;
    if (reg_we) begin we_cnt++; we_addr = reg_addr; we_data = reg_wdata; end
    if (reg_re) begin re_cnt++; re_addr = reg_addr; end
    if (sda_oe) oe_cyc++;
    if (rst_n && ((sda_oe != oe_prev && scl_m) || (reg_we && reg_re))) r9_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;
    wq(Q/2);
    if (glitch_en) begin glitch = 1'b1; wq(1); glitch = 1'b0; end
    wq(Q/2);
    scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin recv_bit(x); b[i] = x; end
    send_bit(~mack);
  endtask

  task automatic hdr(input logic rw, output logic ack);
    logic a2;
    if (mode10) begin
      send_byte({5'b11110, dev_id[9:8], rw}, ack);
      if (!rw && ack) begin send_byte(dev_id[7:0], a2); ack = a2; end
    end else begin
      send_byte({dev_id[6:0], rw}, ack);
    end
  endtask

  task automatic addr_bytes(input logic [21:0] a, input logic [1:0] junk, output logic ok);
    logic a0, a1, a2;
    send_byte({junk, a[21:16]}, a0);
    send_byte(a[15:8], a1);
    send_byte(a[7:0], a2);
    ok = a0 & a1 & a2;
  endtask

  task automatic data_bytes(input logic [31:0] d, input int n, output logic ok);
    logic a;
    ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      send_byte(d[31-8*i -: 8], a);
      ok &= a;
    end
  endtask

  task automatic read_txn(input int n, output logic hack, output logic [31:0] d);
    logic [7:0] b;
    d = '0;
    bus_start();
    hdr(1'b1, hack);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n-1, b);
      d[31-8*i -: 8] = b;
    end
  endtask

  // {mode10, junk[1:0], dev_id[9:0], addr[21:0], data[31:0]}
  localparam logic [66:0] VEC [4] = '{
    {1'b0, 2'b11, 10'h3A5, 22'h12_3456, 32'hDEAD_BEEF},
    {1'b1, 2'b10, 10'h2C3, 22'h3F_00A1, 32'h0123_4567},
    {1'b0, 2'b01, 10'h07F, 22'h00_0000, 32'hFFFF_FFFF},
    {1'b1, 2'b00, 10'h17E, 22'h3F_FFFF, 32'h8000_0001}
  };

  initial begin
    logic ok, a1, a2;
    logic [31:0] rd;
    int w0, r0, o0;

    wq(5);
    // R11 reset values
    chk("R11 oe", 64'(sda_oe), 64'(0));
    chk("R11 we", 64'(reg_we), 64'(0));
    chk("R11 re", 64'(reg_re), 64'(0));
    chk("R11 addr", 64'(reg_addr), 64'(0));
    rst_n = 1'b1;
    wq(10);

    for (int v = 0; v < 4; v++) begin
      logic [21:0] va;
      logic [31:0] vd;
      mode10 = VEC[v][66];
      dev_id = VEC[v][63:54];
      va     = VEC[v][53:32];
      vd     = VEC[v][31:0];
      wq(4);
      w0 = we_cnt; r0 = re_cnt;
      bus_start();
      hdr(1'b0, ok);
      chk(mode10 ? "R2 write header ack" : "R1 write header ack", 64'(ok), 64'(1));
      addr_bytes(va, VEC[v][65:64], ok);
      chk("R4 address acks", 64'(ok), 64'(1));
      data_bytes(vd, 4, ok);
      chk("R4 data acks", 64'(ok), 64'(1));
      bus_stop();
      wq(4);
      chk("R4 one write strobe", 64'(we_cnt - w0), 64'(1));
      chk("R4 write address", 64'(we_addr), 64'(va));
      chk("R4 write data", 64'(we_data), 64'(vd));
      read_txn(4, ok, rd);
      bus_stop();
      wq(4);
      chk("R7 read header ack", 64'(ok), 64'(1));
      chk("R7 one read strobe", 64'(re_cnt - r0), 64'(1));
      chk("R7 read address", 64'(re_addr), 64'(va));
      chk("R7 read data", 64'(rd), 64'(model(va)));
    end

    // R3 7-bit mismatch
    mode10 = 1'b0; dev_id = 10'h155; wq(4);
    w0 = we_cnt; r0 = re_cnt; o0 = oe_cyc;
    bus_start();
    send_byte({7'h54, 1'b0}, ok);
    data_bytes(32'h0011_2233, 2, a1);
    bus_stop(); wq(4);
    chk("R3 nack", 64'(ok), 64'(0));
    chk("R3 sda never driven", 64'(oe_cyc - o0), 64'(0));
    chk("R3 no strobes", 64'(we_cnt - w0 + re_cnt - r0), 64'(0));

    // R2/R3 10-bit second byte mismatch
    mode10 = 1'b1; dev_id = 10'h2C3; wq(4);
    bus_start();
    send_byte({5'b11110, 2'b10, 1'b0}, a1);
    send_byte(8'hC2, a2);
    bus_stop(); wq(4);
    chk("R2 first byte ack", 64'(a1), 64'(1));
    chk("R3 second byte nack", 64'(a2), 64'(0));

    // R5 cancel by STOP after three data bytes
    w0 = we_cnt;
    bus_start(); hdr(1'b0, ok); addr_bytes(22'h11_2233, 2'b00, ok);
    data_bytes(32'hCAFE_F00D, 3, ok);
    bus_stop(); wq(4);
    chk("R5 stop cancels", 64'(we_cnt - w0), 64'(0));

    // R5 cancel by repeated START inside fourth byte
    bus_start(); hdr(1'b0, ok); addr_bytes(22'h11_2233, 2'b00, ok);
    data_bytes(32'hCAFE_F00D, 3, ok);
    for (int i = 0; i < 5; i++) send_bit(i[0]);
    bus_start(); bus_stop(); wq(4);
    chk("R5 repeated start cancels", 64'(we_cnt - w0), 64'(0));

    // R6 address survives cancelled writes
    read_txn(4, ok, rd); bus_stop(); wq(4);
    chk("R6 addr after cancel", 64'(re_addr), 64'(22'h11_2233));

    // R6 address-only write, foreign traffic, then read
    bus_start(); hdr(1'b0, ok); addr_bytes(22'h0A_BCDE, 2'b11, ok); bus_stop();
    bus_start(); send_byte(8'hA0, a1); bus_stop();
    read_txn(4, ok, rd); bus_stop(); wq(4);
    chk("R6 foreign nack", 64'(a1), 64'(0));
    chk("R6 read address", 64'(re_addr), 64'(22'h0A_BCDE));
    chk("R6 read data", 64'(rd), 64'(model(22'h0A_BCDE)));

    // R8 early NACK after two bytes
    mode10 = 1'b0; dev_id = 10'h3A5; wq(4);
    read_txn(2, ok, rd);
    wq(Q);
    chk("R8 sda released", 64'(sda_oe), 64'(0));
    chk("R8 partial data", 64'(rd[31:16]), 64'(model(22'h0A_BCDE) >> 16));
    bus_stop(); wq(4);
    chk("R8 stays released", 64'(sda_oe), 64'(0));

    // R10 one-clock SCL spikes during a write
    w0 = we_cnt;
    glitch_en = 1'b1;
    bus_start(); hdr(1'b0, ok); addr_bytes(22'h2D_5A5A, 2'b10, a1);
    data_bytes(32'h3C3C_A5A5, 4, a2);
    glitch_en = 1'b0;
    bus_stop(); wq(4);
    chk("R10 acks with spikes", 64'(ok & a1 & a2), 64'(1));
    chk("R10 write count", 64'(we_cnt - w0), 64'(1));
    chk("R10 write address", 64'(we_addr), 64'(22'h2D_5A5A));
    chk("R10 write data", 64'(we_data), 64'(32'h3C3C_A5A5));

    // R9 timing and strobe exclusivity over the whole run
    chk("R9 violations", 64'(r9_viol), 64'(0));

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule